// File: doc/BRIEF.md
# Sideband mailbox register bridge

This block gives a host a small register window into registers that live in several internal units behind a sideband fabric. The host reaches it through three 32-bit registers: a command word, an upper-address register and a data register. Writing the command word launches exactly one fabric transaction. The command word names the target unit (port), the opcode and the low eight bits of the unit register offset. The upper offset bits come from the upper-address register, which keeps its value from one transaction to the next.

On the fabric side the bridge raises a request and holds it, with every field stable, until the unit answers or a programmable cycle limit runs out. A read puts the unit's answer into the data register. A write sends whatever the data register held when the command word was written. One port number is reserved and never reachable from the host. A command aimed at it ends at once with a rejection flag and no fabric request.

A host uses the bridge in a fixed order. For a write it loads the data register, sets the upper address if needed, and then writes the command word. For a read it writes the command word and picks up the data register after `done`.

Top module: `sbmb_bridge`

## Requirements
- R1: After reset `busy`, `done`, `sb_req`, `err_reject`, `err_timeout` and `overrun` are 0, and `mdr_q` and `ext_q` are 0.
- R2: A host write to the upper-address register (`reg_addr`=1) or to the data register (`reg_addr`=2) never raises `sb_req` or `busy` and never pulses `done`.
- R3: Suppose the command word (`reg_addr`=0) is written while idle to a port that is not reserved. On the next cycle `busy` and `sb_req` are 1. `sb_opcode` is word bits [31:24], `sb_port` is bits [23:16] and `sb_be` is bits [7:4]. `sb_write` equals opcode bit 0 (odd opcode = write, even = read).
- R4: `sb_addr` is the upper-address register with its low byte forced to zero, OR-ed with command bits [15:8]. The upper-address register reads back with bits [7:0] cleared. It holds its value across transactions until it is rewritten.
- R5: For a write, `sb_wdata` carries the data register value held at the moment the command word was written.
- R6: Suppose a read request sees `sb_rsp`=1 at a clock edge. The data register then takes `sb_rdata`, and `busy` and `sb_req` drop. `done` is 1 for exactly the following cycle.
- R7: Completion of a write transaction leaves the data register unchanged.
- R8: A command to the reserved port (default 5) raises no fabric request. In the next cycle `done` and `err_reject` are 1 and `busy` stays 0, and the data register is unchanged.
- R9: A command word written while `busy` is ignored, and the fields of the outstanding request do not change. It sets `overrun`, which stays 1 until reset.
- R10: Suppose no response arrives while `sb_req` is high for `tmo_limit` cycles (0 counts as 1). The request then drops, with `err_timeout`=1 and `done` pulsed. The data register is unchanged. The next accepted command clears `err_timeout`.
- R11: While `sb_req` stays high, `sb_addr` and `sb_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 upper address, 2 data, 3 unused |
| reg_wdata | input | 32 | Host write data |
| tmo_limit | input | TMO_W | Response wait limit in cycles |
| mdr_q | output | DATA_W | Data register contents |
| ext_q | output | 32 | Upper-address register contents |
| busy | output | 1 | Transaction outstanding |
| done | output | 1 | One-cycle end-of-command pulse |
| err_reject | output | 1 | Last command named the reserved port |
| err_timeout | output | 1 | Last transaction timed out |
| overrun | output | 1 | Sticky: command written while busy |
| sb_req | output | 1 | Fabric request, held until response or timeout |
| sb_write | output | 1 | Request is a write |
| sb_opcode | output | 8 | Request opcode |
| sb_port | output | 8 | Target unit port |
| sb_be | output | 4 | Byte enables |
| sb_addr | output | 32 | Full register offset |
| sb_wdata | output | DATA_W | Write data |
| sb_rsp | input | 1 | Target response strobe |
| sb_rdata | input | DATA_W | Target read data |

## Verification
A corrupted captured request shows up on `sb_addr`, `sb_port` or `sb_wdata` in the cycle right after the command write. The bench samples all three there, and again while the request is held. A wrong state or wait counter shows up as a request that lasts more or fewer cycles than `tmo_limit`, or as a `done` pulse that is missing or doubled. A wrong data-register update appears in `mdr_q` one cycle after the response edge. The scoreboard catches it on the next read-back of the same unit register.

// File: rtl/sbmb_pkg.sv
package sbmb_pkg;

   localparam int ADDR_W   = 32;
   localparam int HOST_W   = 32;
   localparam int OFFLO_W  = 8;
   localparam int EXTHI_W  = ADDR_W - OFFLO_W;

   typedef enum logic [1:0] {
      REG_CMD  = 2'd0,
      REG_EXT  = 2'd1,
      REG_DATA = 2'd2
   } reg_sel_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } seq_state_e;

   typedef struct packed {
      logic [7:0]        opcode;
      logic [7:0]        port;
      logic [3:0]        be;
      logic              write;
      logic [ADDR_W-1:0] addr;
   } sb_fields_t;

endpackage

// File: rtl/sbmb_regs.sv
module sbmb_regs
   import sbmb_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_ext,
   input  logic                 wr_data,
   input  logic [HOST_W-1:0]    wdata,
   input  logic                 load_rd,
   input  logic [DATA_W-1:0]    rd_value,
   output logic [EXTHI_W-1:0]   ext_hi,
   output logic [DATA_W-1:0]    data_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_hi <= '0;
      end else if (wr_ext) begin
         ext_hi <= wdata[HOST_W-1:OFFLO_W];
      end
   end

   // a read result lands after a same-cycle host data write and wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (load_rd) begin
         data_q <= rd_value;
      end else if (wr_data) begin
         data_q <= wdata[DATA_W-1:0];
      end
   end

endmodule

// File: rtl/sbmb_decode.sv
module sbmb_decode
   import sbmb_pkg::*;
#(
   parameter logic [7:0] BLOCKED_PORT = 8'h05,
   parameter bit         BLOCK_EN     = 1'b1
) (
   input  logic [31:4]          cmd_hi,
   input  logic [EXTHI_W-1:0]   ext_hi,
   output sb_fields_t           fields,
   output logic                 reject
);

   always_comb begin
      fields.opcode = cmd_hi[31:24];
      fields.port   = cmd_hi[23:16];
      fields.be     = cmd_hi[7:4];
      fields.write  = cmd_hi[24];
      fields.addr   = {ext_hi, {OFFLO_W{1'b0}}} | {{EXTHI_W{1'b0}}, cmd_hi[15:8]};
   end

   generate
      if (BLOCK_EN) begin : g_block
         assign reject = (cmd_hi[23:16] == BLOCKED_PORT);
      end else begin : g_open
         assign reject = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/sbmb_seq.sv
module sbmb_seq
   import sbmb_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int TMO_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_wr,
   input  logic               reject,
   input  sb_fields_t         fields_in,
   input  logic [DATA_W-1:0]  data_now,
   input  logic [TMO_W-1:0]   tmo_limit,
   input  logic               sb_rsp,
   input  logic [DATA_W-1:0]  sb_rdata,
   output logic               busy,
   output logic               done,
   output logic               err_reject,
   output logic               err_timeout,
   output logic               overrun,
   output sb_fields_t         req_q,
   output logic [DATA_W-1:0]  wdata_q,
   output logic               load_rd,
   output logic [DATA_W-1:0]  rd_value
);

   seq_state_e       st;
   logic [TMO_W-1:0] wait_cnt;
   logic [TMO_W-1:0] last_cnt;

   assign busy     = (st == ST_WAIT);
   assign last_cnt = (tmo_limit == '0) ? '0 : tmo_limit - 1'b1;
   assign load_rd  = busy && sb_rsp && !req_q.write;
   assign rd_value = sb_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         wait_cnt    <= '0;
         done        <= 1'b0;
         err_reject  <= 1'b0;
         err_timeout <= 1'b0;
         overrun     <= 1'b0;
         req_q       <= '0;
         wdata_q     <= '0;
      end else begin
         done <= 1'b0;
         if (st == ST_WAIT) begin
            if (cmd_wr) begin
               overrun <= 1'b1;
            end
            if (sb_rsp) begin
               st       <= ST_IDLE;
               done     <= 1'b1;
               wait_cnt <= '0;
            end else if (wait_cnt >= last_cnt) begin
               st          <= ST_IDLE;
               done        <= 1'b1;
               err_timeout <= 1'b1;
               wait_cnt    <= '0;
            end else begin
               wait_cnt <= wait_cnt + 1'b1;
            end
         end else if (cmd_wr) begin
            err_reject  <= reject;
            err_timeout <= 1'b0;
            if (reject) begin
               done <= 1'b1;
            end else begin
               st       <= ST_WAIT;
               wait_cnt <= '0;
               req_q    <= fields_in;
               wdata_q  <= data_now;
            end
         end
      end
   end

endmodule

// File: rtl/sbmb_bridge.sv
module sbmb_bridge
   import sbmb_pkg::*;
#(
   parameter int         DATA_W       = 32,
   parameter int         TMO_W        = 16,
   parameter logic [7:0] BLOCKED_PORT = 8'h05,
   parameter bit         BLOCK_EN     = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [1:0]         reg_addr,
   input  logic [31:0]        reg_wdata,
   input  logic [TMO_W-1:0]   tmo_limit,
   output logic [DATA_W-1:0]  mdr_q,
   output logic [31:0]        ext_q,
   output logic               busy,
   output logic               done,
   output logic               err_reject,
   output logic               err_timeout,
   output logic               overrun,
   output logic               sb_req,
   output logic               sb_write,
   output logic [7:0]         sb_opcode,
   output logic [7:0]         sb_port,
   output logic [3:0]         sb_be,
   output logic [31:0]        sb_addr,
   output logic [DATA_W-1:0]  sb_wdata,
   input  logic               sb_rsp,
   input  logic [DATA_W-1:0]  sb_rdata
);

   generate
      if (DATA_W < 8 || DATA_W > HOST_W) begin : g_bad_data_w
         $error("sbmb_bridge: DATA_W must lie in 8..32");
      end
      if (TMO_W < 2) begin : g_bad_tmo_w
         $error("sbmb_bridge: TMO_W must be at least 2");
      end
   endgenerate

   logic               cmd_wr, wr_ext, wr_data;
   logic [EXTHI_W-1:0] ext_hi;
   sb_fields_t         fields;
   sb_fields_t         req_q;
   logic               reject;
   logic               load_rd;
   logic [DATA_W-1:0]  rd_value;

   assign cmd_wr  = reg_wr && (reg_addr == REG_CMD);
   assign wr_ext  = reg_wr && (reg_addr == REG_EXT);
   assign wr_data = reg_wr && (reg_addr == REG_DATA);

   sbmb_regs #(.DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ext   (wr_ext),
      .wr_data  (wr_data),
      .wdata    (reg_wdata),
      .load_rd  (load_rd),
      .rd_value (rd_value),
      .ext_hi   (ext_hi),
      .data_q   (mdr_q)
   );

   sbmb_decode #(.BLOCKED_PORT(BLOCKED_PORT), .BLOCK_EN(BLOCK_EN)) u_decode (
      .cmd_hi (reg_wdata[31:4]),
      .ext_hi (ext_hi),
      .fields (fields),
      .reject (reject)
   );

   sbmb_seq #(.DATA_W(DATA_W), .TMO_W(TMO_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_wr      (cmd_wr),
      .reject      (reject),
      .fields_in   (fields),
      .data_now    (mdr_q),
      .tmo_limit   (tmo_limit),
      .sb_rsp      (sb_rsp),
      .sb_rdata    (sb_rdata),
      .busy        (busy),
      .done        (done),
      .err_reject  (err_reject),
      .err_timeout (err_timeout),
      .overrun     (overrun),
      .req_q       (req_q),
      .wdata_q     (sb_wdata),
      .load_rd     (load_rd),
      .rd_value    (rd_value)
   );

   assign ext_q     = {ext_hi, {OFFLO_W{1'b0}}};
   assign sb_req    = busy;
   assign sb_write  = req_q.write;
   assign sb_opcode = req_q.opcode;
   assign sb_port   = req_q.port;
   assign sb_be     = req_q.be;
   assign sb_addr   = req_q.addr;

endmodule

// File: rtl/sbmb_bridge_chk.sv
module sbmb_bridge_chk #(
   parameter int         DATA_W       = 32,
   parameter int         TMO_W        = 16,
   parameter logic [7:0] BLOCKED_PORT = 8'h05,
   parameter bit         BLOCK_EN     = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_wr,
   input logic [1:0]         reg_addr,
   input logic [31:0]        reg_wdata,
   input logic [TMO_W-1:0]   tmo_limit,
   input logic               busy,
   input logic               done,
   input logic               err_reject,
   input logic               overrun,
   input logic               sb_req,
   input logic               sb_write,
   input logic               sb_rsp,
   input logic [31:0]        sb_addr,
   input logic [DATA_W-1:0]  sb_wdata,
   input logic [DATA_W-1:0]  mdr_q
);

   logic             cmd_w, blk;
   logic [TMO_W-1:0] held_cnt;
   logic [TMO_W-1:0] allowed;

   assign cmd_w   = reg_wr && (reg_addr == 2'd0);
   assign blk     = BLOCK_EN && (reg_wdata[23:16] == BLOCKED_PORT);
   assign allowed = (tmo_limit == '0) ? {{(TMO_W-1){1'b0}}, 1'b1} : tmo_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      held_cnt <= '0;
      else if (sb_req) held_cnt <= held_cnt + 1'b1;
      else             held_cnt <= '0;
   end

   assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr != 2'd0 && !busy) |=> (!sb_req && !done));

   assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && !busy && !blk) |=> (sb_req && busy));

   assert_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sb_req && sb_rsp) |=> (!busy && done));

   assert_one_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_write_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sb_req && sb_rsp && sb_write && !(reg_wr && reg_addr == 2'd2)) |=> $stable(mdr_q));

   assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && !busy && blk) |=> (done && err_reject && !sb_req));

   assert_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && busy) |=> overrun);

   assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   assert_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sb_req |-> (held_cnt < allowed));

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sb_req && $past(sb_req)) |-> ($stable(sb_addr) && $stable(sb_wdata)));

endmodule

bind sbmb_bridge sbmb_bridge_chk #(
   .DATA_W(DATA_W), .TMO_W(TMO_W), .BLOCKED_PORT(BLOCKED_PORT), .BLOCK_EN(BLOCK_EN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .tmo_limit (tmo_limit),
   .busy      (busy),
   .done      (done),
   .err_reject(err_reject),
   .overrun   (overrun),
   .sb_req    (sb_req),
   .sb_write  (sb_write),
   .sb_rsp    (sb_rsp),
   .sb_addr   (sb_addr),
   .sb_wdata  (sb_wdata),
   .mdr_q     (mdr_q)
);

// File: tb/sbmb_bridge_tb.sv
module sbmb_bridge_tb;

   localparam logic [7:0] SILENT = 8'h07;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [15:0] tmo_limit = 16'd20;
   logic [31:0] mdr_q, ext_q, sb_addr, sb_wdata, sb_rdata;
   logic        busy, done, err_reject, err_timeout, overrun;
   logic        sb_req, sb_write, sb_rsp;
   logic [7:0]  sb_opcode, sb_port;
   logic [3:0]  sb_be;

   int n_chk = 0;
   int n_err = 0;
   int lat = 1;
   int wcnt = 0;
   logic [31:0] mem [4][16];

   always #5 clk = ~clk;

   sbmb_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .tmo_limit(tmo_limit), .mdr_q(mdr_q), .ext_q(ext_q),
      .busy(busy), .done(done), .err_reject(err_reject), .err_timeout(err_timeout),
      .overrun(overrun), .sb_req(sb_req), .sb_write(sb_write), .sb_opcode(sb_opcode),
      .sb_port(sb_port), .sb_be(sb_be), .sb_addr(sb_addr), .sb_wdata(sb_wdata),
      .sb_rsp(sb_rsp), .sb_rdata(sb_rdata)
   );

   // behavioural unit registers: respond lat negedges after the request appears
   initial begin
      sb_rsp = 1'b0;
      sb_rdata = '0;
      for (int p = 0; p < 4; p++)
         for (int i = 0; i < 16; i++) mem[p][i] = '0;
   end

   always @(negedge clk) begin
      if (!rst_n || sb_rsp) begin
         sb_rsp = 1'b0;
         wcnt = 0;
      end else if (sb_req && sb_port != SILENT) begin
         if (wcnt >= lat) begin
            sb_rsp = 1'b1;
            if (sb_write) mem[sb_port[1:0]][sb_addr[3:0]] = sb_wdata;
            else          sb_rdata = mem[sb_port[1:0]][sb_addr[3:0]];
         end else begin
            wcnt++;
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic host_wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   function automatic logic [31:0] cmd(input logic [7:0] op, input logic [7:0] port,
                                       input logic [7:0] off);
      return {op, port, off, 4'hF, 4'h0};
   endfunction

   task automatic wait_done();
      for (int g = 0; g < 100 && !done; g++) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 busy", busy, 0);
      check("R1 sb_req", sb_req, 0);
      check("R1 flags", {done, err_reject, err_timeout, overrun}, 0);
      check("R1 data", mdr_q, 0);
      check("R1 ext", ext_q, 0);
   endtask

   task automatic t_write();
      lat = 2;
      host_wr(2'd2, 32'hA5A5_1234);
      check("R2 data write starts nothing", {sb_req, busy, done}, 0);
      host_wr(2'd0, cmd(8'h11, 8'h01, 8'h03));
      check("R3 req", {sb_req, busy}, 2'b11);
      check("R3 write bit", sb_write, 1);
      check("R3 opcode", sb_opcode, 8'h11);
      check("R3 port", sb_port, 8'h01);
      check("R3 be", sb_be, 4'hF);
      check("R4 addr", sb_addr, 32'h0000_0003);
      check("R5 wdata", sb_wdata, 32'hA5A5_1234);
      wait_done();
      check("R6 done", {done, busy}, 2'b10);
      check("R7 data kept", mdr_q, 32'hA5A5_1234);
      check("R5 unit stored", mem[1][3], 32'hA5A5_1234);
   endtask

   task automatic t_read();
      lat = 0;
      host_wr(2'd2, 32'h0);
      host_wr(2'd0, cmd(8'h10, 8'h01, 8'h03));
      check("R3 read bit", sb_write, 0);
      wait_done();
      check("R6 read result", mdr_q, 32'hA5A5_1234);
      @(negedge clk);
      check("R6 single pulse", {done, busy, sb_req}, 0);
   endtask

   task automatic t_ext();
      lat = 1;
      host_wr(2'd1, 32'h0001_23FF);
      check("R4 ext low byte cleared", ext_q, 32'h0001_2300);
      check("R2 ext write starts nothing", {sb_req, busy, done}, 0);
      host_wr(2'd2, 32'hCAFE_0042);
      host_wr(2'd0, cmd(8'h21, 8'h02, 8'h42));
      check("R4 combined addr", sb_addr, 32'h0001_2342);
      wait_done();
      host_wr(2'd2, 32'h0);
      host_wr(2'd0, cmd(8'h20, 8'h02, 8'h42));
      check("R4 ext sticky", sb_addr, 32'h0001_2342);
      wait_done();
      check("R6 scoreboard", mdr_q, 32'hCAFE_0042);
   endtask

   task automatic t_reject();
      host_wr(2'd0, cmd(8'h10, 8'h05, 8'h01));
      check("R8 no request", {sb_req, busy}, 0);
      check("R8 done+reject", {done, err_reject}, 2'b11);
      @(negedge clk);
      check("R8 pulse ends", done, 0);
      check("R8 data kept", mdr_q, 32'hCAFE_0042);
   endtask

   task automatic t_timeout();
      int n = 0;
      logic [31:0] a0;
      tmo_limit = 16'd5;
      host_wr(2'd0, cmd(8'h10, SILENT, 8'h01));
      a0 = sb_addr;
      while (busy && n < 50) begin
         n++;
         if (sb_addr !== a0) check("R11 addr held", sb_addr, a0);
         @(negedge clk);
      end
      check("R10 request length", n, 5);
      check("R10 done+timeout", {done, err_timeout, sb_req}, 3'b110);
      check("R10 data kept", mdr_q, 32'hCAFE_0042);
      tmo_limit = 16'd20;
      host_wr(2'd0, cmd(8'h10, 8'h01, 8'h03));
      wait_done();
      check("R10 timeout cleared", err_timeout, 0);
   endtask

   task automatic t_overrun();
      lat = 3;
      host_wr(2'd0, cmd(8'h10, 8'h01, 8'h03));
      host_wr(2'd0, cmd(8'h11, 8'h02, 8'h05));
      check("R9 port kept", sb_port, 8'h01);
      check("R9 kind kept", sb_write, 0);
      check("R9 overrun", overrun, 1);
      wait_done();
      check("R9 read ok", mdr_q, 32'hA5A5_1234);
      lat = 0;
      host_wr(2'd0, cmd(8'h10, 8'h02, 8'h05));
      wait_done();
      check("R9 ignored write had no effect", mdr_q, 32'h0);
      check("R9 overrun sticky", overrun, 1);
      do_reset();
      check("R1 overrun cleared", overrun, 0);
      check("R1 ext cleared", ext_q, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write();
      t_read();
      t_ext();
      t_reject();
      t_timeout();
      t_overrun();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule